// File: doc/BRIEF.md
# Sample FIFO with Status Register

This block holds up to eight 12-bit two's-complement conversion results in arrival order, together with a per-sample out-of-range tag. Location 0 always drives the output word. Each read removes that word, and the remaining entries move down one place toward location 0. A converter pulses `conv_done` with a result and its tag. A host pops words with `pop` and reads a 12-bit status word on `status_word` at any time.

The host can also write the status/control register. That write sets an almost-full threshold, masks the almost-full flag, latches a bus-drive control bit for logic outside the block, or forces a complete reset. The active-low `almost_full_n` output goes low when a conversion brings the stored word count up to the programmed threshold, so the host can be interrupted after any number of conversions from one to eight.

Top module: `sample_fifo_ctl`

## Requirements
- R1: Words leave in arrival order. `head_data` always shows the oldest stored word, and after each pop the next oldest word takes its place.
- R2: A conversion that arrives while eight words are stored, with no pop in the same cycle, is dropped. Status bit 6 then reads 1 and stays 1 until reset.
- R3: A pop while the block is empty changes nothing, and `head_data` keeps the last word it showed. Status bit 4 reads 1 exactly when no word is stored.
- R4: Status bits 2..0 read the number of stored words minus one, and read 0 when the block is empty.
- R5: In a cycle with `conv_done` high, if the flag is not masked and the resulting word count is at least the threshold in bits 10..8 plus one, `almost_full_n` goes low on the next edge. Status bit 11 always equals `almost_full_n`.
- R6: A pop that leaves fewer than threshold-plus-one words drives `almost_full_n` high. While mask bit 7 holds 1, `almost_full_n` stays high. Bits 10..8 and bit 7 read back the values last written.
- R7: Status bit 5 reads 1 when any stored word carries the out-of-range tag. Status bit 3 reads 1 when the word at location 0 carries the tag and the block is not empty.
- R8: Either `rst_n` low or a register write with bit 6 set resets the block on the next edge. After it, every location holds 0x800, all tags and control bits are 0, `almost_full_n` is 1 and `status_word` reads 0x810.
- R9: A push and a valid pop in the same cycle are both performed and the word count does not change. This holds when the block is full, and a push into an empty block with a pop in the same cycle stores the new word.
- R10: Bit 5 of a register write is latched and driven on `drive_while_busy`. Bits 4..0 of a register write have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| conv_done | input | 1 | Conversion result strobe |
| conv_data | input | 12 | Two's-complement result |
| conv_oor | input | 1 | Out-of-range tag for the result |
| pop | input | 1 | Remove the word at location 0 |
| reg_wr | input | 1 | Status/control register write strobe |
| reg_wdata | input | 12 | Register write data |
| head_data | output | 12 | Word at location 0 |
| status_word | output | 12 | Status word |
| almost_full_n | output | 1 | Active-low almost-full flag |
| drive_while_busy | output | 1 | Latched control bit 5 |

## Verification
For every threshold from 0 to 7, the bench fills the block past capacity and then drains it with extra pops. This separates the exact conversion at which the flag falls, the pop at which it rises, the overrun point and the empty hold. Out-of-range tags are placed on single words so that the any-tag bit and the head-tag bit can be told apart as the tagged word moves toward location 0. Same-cycle push and pop are tried at partial, full and empty occupancy to expose count errors at the ends. Mask writes, writes with the ignored low bits set, and soft reset each show whether a register write reaches only the fields it should.

// File: rtl/sfifo_pkg.sv
// Shared constants for the sample FIFO: status word field positions
// and reset values. Assumes a 12-bit status/control word.
package sfifo_pkg;
    localparam int SW_W       = 12;
    localparam int B_AF       = 11;  // almost-full mirror
    localparam int B_THR_LO   = 8;   // threshold field low bit
    localparam int B_MASK     = 7;   // flag mask
    localparam int B_OVR      = 6;   // overrun on read, reset on write
    localparam int B_OOR_ANY  = 5;   // any tag on read, drive control on write
    localparam int B_EMPTY    = 4;
    localparam int B_OOR_HEAD = 3;
    localparam logic [SW_W-1:0] STATUS_AT_RESET = 12'h810;
endpackage

// File: rtl/sfifo_occ.sv
// Occupancy tracker: decides which pushes and pops take effect, keeps
// the stored word count and the sticky overrun bit.
// Assumes pop and conv_done are single-cycle strobes in the clk domain.
module sfifo_occ #(
    parameter int DEPTH = 8,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wipe,
    input  logic             conv_done,
    input  logic             pop,
    output logic [OCC_W-1:0] occ,
    output logic [OCC_W-1:0] occ_nxt,
    output logic             push_ok,
    output logic             pop_ok,
    output logic             overrun
);
    localparam logic [OCC_W-1:0] FULL = OCC_W'(DEPTH);

    // Qualify strobes: pop only when something is stored, push when room or freed
    always_comb begin
        pop_ok  = pop && (occ != '0);
        push_ok = conv_done && ((occ != FULL) || pop_ok);
        occ_nxt = occ;
        if (push_ok && !pop_ok) occ_nxt = occ + 1'b1;
        if (pop_ok && !push_ok) occ_nxt = occ - 1'b1;
    end

    // Word count register
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) occ <= '0;
        else                occ <= occ_nxt;
    end

    // Sticky record of a dropped conversion
    always_ff @(posedge clk) begin
        if (!rst_n || wipe)            overrun <= 1'b0;
        else if (conv_done && !push_ok) overrun <= 1'b1;
    end
endmodule

// File: rtl/sfifo_store.sv
// Shift-down storage: location 0 is the output; a pop moves every entry
// down one place, a push writes at the first free location. Tags move
// with their words. When the last word is popped, location 0 keeps it.
// Assumes push_ok/pop_ok are already qualified by sfifo_occ.
module sfifo_store #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 8,
    localparam int OCC_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe,
    input  logic              push_ok,
    input  logic              pop_ok,
    input  logic [OCC_W-1:0]  occ,
    input  logic [DATA_W-1:0] din,
    input  logic              din_oor,
    output logic [DATA_W-1:0] head,
    output logic              head_oor,
    output logic              any_oor
);
    localparam logic [DATA_W-1:0] MID_CODE = {1'b1, {(DATA_W-1){1'b0}}};

    logic [DATA_W-1:0] word [DEPTH];
    logic [DEPTH-1:0]  tag;
    logic [OCC_W-1:0]  wr_idx;
    logic              shift;

    // Write slot and shift enable
    always_comb begin
        wr_idx = occ - OCC_W'(pop_ok);
        shift  = pop_ok && (occ > OCC_W'(1));
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic load_here;
        assign load_here = push_ok && (wr_idx == OCC_W'(i));
        if (i < DEPTH - 1) begin : g_mid
            // Slot i: load new word, or take the one above on a shift
            always_ff @(posedge clk) begin
                if (!rst_n || wipe) begin
                    word[i] <= MID_CODE;
                    tag[i]  <= 1'b0;
                end else if (load_here) begin
                    word[i] <= din;
                    tag[i]  <= din_oor;
                end else if (shift) begin
                    word[i] <= word[i+1];
                    tag[i]  <= tag[i+1];
                end
            end
        end else begin : g_top
            // Top slot: only ever loaded directly
            always_ff @(posedge clk) begin
                if (!rst_n || wipe) begin
                    word[i] <= MID_CODE;
                    tag[i]  <= 1'b0;
                end else if (load_here) begin
                    word[i] <= din;
                    tag[i]  <= din_oor;
                end
            end
        end
    end

    // Tag summary over occupied slots and head outputs
    always_comb begin
        any_oor = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            if (OCC_W'(i) < occ) any_oor = any_oor | tag[i];
        head     = word[0];
        head_oor = tag[0] && (occ != '0);
    end
endmodule

// File: rtl/sfifo_cfg.sv
// Control fields and almost-full flag. Holds threshold, flag mask and the
// drive control bit; evaluates the flag on conversions and pops.
// Assumes occ_nxt is the word count after this cycle's push/pop.
module sfifo_cfg #(
    parameter int DEPTH = 8,
    localparam int OCC_W = $clog2(DEPTH + 1),
    localparam int THR_W = $clog2(DEPTH)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wipe,
    input  logic                   reg_wr,
    input  logic [sfifo_pkg::SW_W-1:0] reg_wdata,
    input  logic                   conv_done,
    input  logic                   pop_ok,
    input  logic [OCC_W-1:0]       occ_nxt,
    output logic [THR_W-1:0]       thr,
    output logic                   mask,
    output logic                   drv_en,
    output logic                   af_n
);
    import sfifo_pkg::*;

    logic             mask_nxt;
    logic [OCC_W-1:0] limit;
    logic             af_nxt;

    // Flag next state: mask wins, then conversion, then pop
    always_comb begin
        mask_nxt = reg_wr ? reg_wdata[B_MASK] : mask;
        limit    = OCC_W'(thr) + 1'b1;
        af_nxt   = af_n;
        if (mask_nxt)                              af_nxt = 1'b1;
        else if (conv_done && (occ_nxt >= limit))  af_nxt = 1'b0;
        else if (pop_ok && (occ_nxt < limit))      af_nxt = 1'b1;
    end

    // Writable control fields
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) begin
            thr    <= '0;
            mask   <= 1'b0;
            drv_en <= 1'b0;
        end else if (reg_wr) begin
            thr    <= reg_wdata[B_THR_LO +: THR_W];
            mask   <= reg_wdata[B_MASK];
            drv_en <= reg_wdata[B_OOR_ANY];
        end
    end

    // Almost-full flag register
    always_ff @(posedge clk) begin
        if (!rst_n || wipe) af_n <= 1'b1;
        else                af_n <= af_nxt;
    end
endmodule

// File: rtl/sample_fifo_ctl.sv
// Top of the sample FIFO: ties occupancy, storage and control together
// and assembles the status word. A register write with bit 6 set is a
// full synchronous reset. Assumes DEPTH = 8 for the 3-bit status fields.
module sample_fifo_ctl #(
    parameter int DATA_W = 12,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              conv_oor,
    input  logic              pop,
    input  logic              reg_wr,
    input  logic [11:0]       reg_wdata,
    output logic [DATA_W-1:0] head_data,
    output logic [11:0]       status_word,
    output logic              almost_full_n,
    output logic              drive_while_busy
);
    import sfifo_pkg::*;
    localparam int OCC_W = $clog2(DEPTH + 1);
    localparam int THR_W = $clog2(DEPTH);

    logic             wipe;
    logic [OCC_W-1:0] occ, occ_nxt;
    logic             push_ok, pop_ok, overrun;
    logic             head_oor, any_oor;
    logic [THR_W-1:0] thr;
    logic             mask;
    logic [THR_W-1:0] cnt_field;

    // Soft reset request from the control write
    assign wipe = reg_wr && reg_wdata[B_OVR];

    sfifo_occ #(.DEPTH(DEPTH)) u_occ (
        .clk(clk), .rst_n(rst_n), .wipe(wipe), .conv_done(conv_done),
        .pop(pop), .occ(occ), .occ_nxt(occ_nxt), .push_ok(push_ok),
        .pop_ok(pop_ok), .overrun(overrun)
    );

    sfifo_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wipe(wipe), .push_ok(push_ok),
        .pop_ok(pop_ok), .occ(occ), .din(conv_data), .din_oor(conv_oor),
        .head(head_data), .head_oor(head_oor), .any_oor(any_oor)
    );

    sfifo_cfg #(.DEPTH(DEPTH)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wipe(wipe), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .conv_done(conv_done), .pop_ok(pop_ok),
        .occ_nxt(occ_nxt), .thr(thr), .mask(mask), .drv_en(drive_while_busy),
        .af_n(almost_full_n)
    );

    // Status word assembly; count field is highest occupied index
    always_comb begin
        cnt_field = (occ == '0) ? '0 : THR_W'(occ - 1'b1);
        status_word                          = '0;
        status_word[B_AF]                    = almost_full_n;
        status_word[B_THR_LO +: THR_W]       = thr;
        status_word[B_MASK]                  = mask;
        status_word[B_OVR]                   = overrun;
        status_word[B_OOR_ANY]               = any_oor;
        status_word[B_EMPTY]                 = (occ == '0);
        status_word[B_OOR_HEAD]              = head_oor;
        status_word[THR_W-1:0]               = cnt_field;
    end
endmodule

// File: rtl/sfifo_checker.sv
// Property checker for sample_fifo_ctl, bound to every instance.
module sfifo_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        conv_done,
    input logic        pop,
    input logic        reg_wr,
    input logic [11:0] reg_wdata,
    input logic [11:0] head_data,
    input logic [11:0] status_word,
    input logic        almost_full_n
);
    logic quiet_wr;
    assign quiet_wr = !(reg_wr && reg_wdata[6]);

    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[6] && quiet_wr) |=> status_word[6]); // R2

    AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[4] && pop && !conv_done && quiet_wr) |=> $stable(head_data)); // R3

    AST_FIRST_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[4] && conv_done && quiet_wr) |=> (!status_word[4] && status_word[2:0] == 3'd0)); // R4

    AST_MASK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        status_word[7] |-> almost_full_n); // R6

    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (status_word == 12'h810 && head_data == 12'h800)); // R8
endmodule

bind sample_fifo_ctl sfifo_checker u_chk (.*);

// File: tb/sample_fifo_ctl_bench.sv
module sample_fifo_ctl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_done = 1'b0;
    logic [11:0] conv_data = '0;
    logic        conv_oor = 1'b0;
    logic        pop = 1'b0;
    logic        reg_wr = 1'b0;
    logic [11:0] reg_wdata = '0;
    logic [11:0] head_data;
    logic [11:0] status_word;
    logic        almost_full_n;
    logic        drive_while_busy;

    int n_checks = 0;
    int n_errors = 0;

    // reference state
    logic [12:0] q[$];
    logic [11:0] m_head;
    logic        m_ovr, m_mask, m_drv, m_af;
    logic [2:0]  m_thr;

    always #(CLK_PERIOD/2) clk = ~clk;

    sample_fifo_ctl u_sample_fifo_ctl (
        .clk(clk), .rst_n(rst_n), .conv_done(conv_done), .conv_data(conv_data),
        .conv_oor(conv_oor), .pop(pop), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .head_data(head_data), .status_word(status_word),
        .almost_full_n(almost_full_n), .drive_while_busy(drive_while_busy)
    );

    task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        q.delete();
        m_head = 12'h800; m_ovr = 0; m_mask = 0; m_drv = 0; m_af = 1; m_thr = 0;
    endtask

    task automatic model_step(input logic c, input logic [11:0] d, input logic o,
                              input logic p, input logic w, input logic [11:0] wd, input logic r);
        int n;
        logic popok, pushok;
        if (!r || (w && wd[6])) begin
            model_reset();
            return;
        end
        n = q.size();
        popok  = p && n > 0;
        pushok = c && (n < 8 || popok);
        if (c && !pushok) m_ovr = 1;
        if (popok) void'(q.pop_front());
        if (pushok) q.push_back({o, d});
        if (q.size() > 0) m_head = q[0][11:0];
        if (w) m_mask = wd[7];
        if (m_mask) m_af = 1;
        else if (c && q.size() >= int'(m_thr) + 1) m_af = 0;
        else if (popok && q.size() < int'(m_thr) + 1) m_af = 1;
        if (w) begin m_thr = wd[10:8]; m_drv = wd[5]; end
    endtask

    task automatic check_all();
        int n;
        logic any;
        n = q.size();
        any = 0;
        foreach (q[i]) any |= q[i][12];
        chk("R1 head", head_data, m_head);
        chk("R4 count", {9'd0, status_word[2:0]}, (n == 0) ? 12'd0 : 12'(n - 1));
        chk("R3 empty", {11'd0, status_word[4]}, {11'd0, n == 0});
        chk("R2 overrun", {11'd0, status_word[6]}, {11'd0, m_ovr});
        chk("R5 flag", {11'd0, almost_full_n}, {11'd0, m_af});
        chk("R5 flag mirror", {11'd0, status_word[11]}, {11'd0, m_af});
        chk("R6 fields", {8'd0, status_word[10:7]}, {8'd0, m_thr, m_mask});
        chk("R7 tags", {10'd0, status_word[5], status_word[3]},
            {10'd0, any, (n > 0) && q[0][12]});
        chk("R10 drive", {11'd0, drive_while_busy}, {11'd0, m_drv});
    endtask

    // One cycle: drive at negedge, step model, check at next negedge
    task automatic cyc(input logic c, input logic [11:0] d, input logic o,
                       input logic p, input logic w, input logic [11:0] wd);
        conv_done = c; conv_data = d; conv_oor = o; pop = p; reg_wr = w; reg_wdata = wd;
        model_step(c, d, o, p, w, wd, rst_n);
        @(negedge clk);
        check_all();
        conv_done = 0; pop = 0; reg_wr = 0;
    endtask

    task automatic push(input logic [11:0] d, input logic o); cyc(1, d, o, 0, 0, '0); endtask
    task automatic pull(); cyc(0, '0, 0, 1, 0, '0); endtask
    task automatic wreg(input logic [11:0] wd); cyc(0, '0, 0, 0, 1, wd); endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_errors++; n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        model_reset();
        @(negedge clk);
        cyc(0, '0, 0, 0, 0, '0);                 // R8 reset by pin
        chk("R8 reset status", status_word, 12'h810);
        rst_n = 1'b1;
        // Threshold sweep: fill past capacity, drain past empty (R1..R7)
        for (int t = 0; t < 8; t++) begin
            wreg(12'h040);                       // R8 soft reset
            chk("R8 soft reset status", status_word, 12'h810);
            wreg(12'(t << 8));
            for (int k = 0; k < 9; k++) push(12'(12'h900 + t * 16 + k), k == (t % 8));
            for (int k = 0; k < 10; k++) pull(); // R3 extra pops on empty
        end
        // Same-cycle push and pop (R9)
        wreg(12'h040);
        wreg(12'h300);
        for (int k = 0; k < 3; k++) push(12'(12'h7F0 + k), 0);
        for (int k = 0; k < 4; k++) cyc(1, 12'(12'h100 + k), k[0], 1, 0, '0);
        for (int k = 0; k < 5; k++) push(12'(12'h200 + k), 0);
        cyc(1, 12'h555, 1, 1, 0, '0);            // R9 full
        for (int k = 0; k < 8; k++) pull();
        cyc(1, 12'hABC, 0, 1, 0, '0);            // R9 empty with pop
        chk("R9 empty push kept", head_data, 12'hABC);
        // Mask bit and ignored low bits (R6, R10)
        wreg(12'h040);
        wreg(12'h080);
        push(12'h011, 0); push(12'h022, 1);
        wreg(12'h03F);                           // R10 bits 4..0 set, bit5 latched
        push(12'h033, 0);
        pull(); pull(); pull(); pull();
        rst_n = 1'b0;                             // R8 pin reset after activity
        cyc(0, '0, 0, 0, 0, '0);
        chk("R8 pin reset head", head_data, 12'h800);
        rst_n = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule